// File: doc/BRIEF.md
# Crossbar Column Output Arbiter with Remove-Request Priority

This block is the output-side scheduler for one output port of an N-by-N buffered crossbar. The crossbar holds one small buffer at every input/output crosspoint; this arbiter watches the N buffers of its own column and, in each cell slot, chooses the one whose head cell goes to the output link. Every clock cycle is one cell slot.

Two kinds of information reach it from the inputs: a flag per input saying that its crosspoint buffer in this column holds at least one cell, and a flag per input carrying a remove-request from that input's scheduler. Valid remove-requests (those aimed at a buffer that really holds a cell) win over plain occupancy. Among the chosen candidate set the arbiter searches circularly from a single shared priority pointer, registers a one-hot grant, and in the same cycle sends a one-cycle delivery notice back to the granted input so that it can update its view of the buffer. The pointer then moves one place past the winner.

The grant and notice are plain control outputs: they are not back-pressured, and the output link is assumed to accept one cell in every slot that carries a grant.

Top module: `xos_out_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, gnt_o, gnt_vld_o and notify_o are all zero, and the priority pointer starts at input 0.
- R2: When at least one input has both its rmreq_i and occ_i bit set, the grant goes to the first such input found by searching upward from the pointer with wrap-around, even if other occupied buffers lie closer to the pointer.
- R3: A rmreq_i bit whose occ_i bit is zero is ignored; it neither wins nor blocks round-robin selection among the occupied buffers.
- R4: When no valid remove-request is present, the grant goes to the first input with occ_i set, searching upward from the pointer with wrap-around.
- R5: After each grant the pointer becomes the granted index plus one, wrapping from N_PORTS-1 to 0.
- R6: When occ_i is all zero, the next cycle has gnt_vld_o low, gnt_o zero, notify_o zero, and the pointer unchanged.
- R7: Inputs sampled at a clock edge produce their grant on the outputs right after that edge (one register stage); gnt_o is one-hot when gnt_vld_o is high and zero otherwise; bit i of gnt_o stands for input i.
- R8: notify_o equals gnt_o in every cycle, so each delivery gives exactly one one-cycle pulse on the granted input's line.
- R9: The remove-request path and the round-robin path share one pointer: a grant from either path moves the pointer used by the next arbitration of either kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cell slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_i | input | N_PORTS | Bit i set: crosspoint buffer of input i in this column holds a cell |
| rmreq_i | input | N_PORTS | Bit i set: input i asks that its cell in this column be removed |
| gnt_o | output | N_PORTS | One-hot grant, bit i selects input i's buffer |
| gnt_vld_o | output | 1 | A grant is issued this slot |
| notify_o | output | N_PORTS | Delivery notice pulse to the granted input |

## Verification
The remove-request path and the plain round-robin path can both have candidates in one slot, and an invalid request can arrive beside valid ones, so the block must pick the request path and still move the shared pointer the same way. Directed slots place a valid request behind the pointer while occupied buffers sit just ahead of it, aim requests at empty buffers, and follow a request grant with a plain grant to show the shared pointer. Seeded random occupancy and sparse request patterns then mix both paths slot after slot, and each grant, valid flag and notice is compared with a bench model that holds its own pointer.

// File: rtl/xos_pkg.sv
package xos_pkg;

  // Which candidate set produced the winner of a slot.
  typedef enum logic [0:0] {
    SRC_REQ = 1'b0,
    SRC_RR  = 1'b1
  } xos_src_e;

  // Next position after v in a ring of n entries.
  function automatic int unsigned xos_wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/xos_req_mask.sv
module xos_req_mask #(
  parameter int N_PORTS = 8
) (
  input  logic [N_PORTS-1:0] req_i,
  input  logic [N_PORTS-1:0] occ_i,
  output logic [N_PORTS-1:0] eff_o
);
  // A request only counts when its buffer actually holds a cell.
  for (genvar i = 0; i < N_PORTS; i++) begin : g_bit
    assign eff_o[i] = req_i[i] & occ_i[i];
  end
endmodule

// File: rtl/xos_rr_pick.sv
module xos_rr_pick #(
  parameter int N_PORTS = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_PORTS-1:0] cand_i,
  input  logic [IDX_W-1:0]   base_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic             hit_hi;
  logic             hit_lo;
  logic [IDX_W-1:0] idx_hi;
  logic [IDX_W-1:0] idx_lo;

  // Lowest candidate at or above base; otherwise lowest candidate overall.
  always_comb begin
    hit_hi = 1'b0;
    hit_lo = 1'b0;
    idx_hi = '0;
    idx_lo = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        hit_lo = 1'b1;
        idx_lo = IDX_W'(i);
        if (i >= int'(base_i)) begin
          hit_hi = 1'b1;
          idx_hi = IDX_W'(i);
        end
      end
    end
    any_o = hit_lo;
    idx_o = hit_hi ? idx_hi : idx_lo;
  end
endmodule

// File: rtl/xos_grant_reg.sv
module xos_grant_reg #(
  parameter int N_PORTS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_any_i,
  input  logic [N_PORTS-1:0] win_oh_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic               gnt_vld_o,
  output logic [N_PORTS-1:0] notify_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_o     <= '0;
      gnt_vld_o <= 1'b0;
      notify_o  <= '0;
    end else begin
      gnt_o     <= win_oh_i;
      gnt_vld_o <= win_any_i;
      notify_o  <= win_oh_i;
    end
  end
endmodule

// File: rtl/xos_out_sched.sv
module xos_out_sched
  import xos_pkg::*;
#(
  parameter int N_PORTS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] occ_i,
  input  logic [N_PORTS-1:0] rmreq_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic               gnt_vld_o,
  output logic [N_PORTS-1:0] notify_o
);
  localparam int IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int N_PATHS = 2;

  logic [IDX_W-1:0]   ptr_q;
  logic [IDX_W-1:0]   ptr_nxt;
  logic [N_PORTS-1:0] eff_req;
  logic [N_PORTS-1:0] cand_set [N_PATHS];
  logic [N_PATHS-1:0] path_any;
  logic [IDX_W-1:0]   path_idx [N_PATHS];
  xos_src_e           win_src;
  logic               win_any;
  logic [IDX_W-1:0]   win_idx;
  logic [N_PORTS-1:0] win_oh;

  xos_req_mask #(.N_PORTS(N_PORTS)) u_mask (
    .req_i (rmreq_i),
    .occ_i (occ_i),
    .eff_o (eff_req)
  );

  assign cand_set[int'(SRC_REQ)] = eff_req;
  assign cand_set[int'(SRC_RR)]  = occ_i;

  // Both candidate sets are searched from the same pointer in parallel.
  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    xos_rr_pick #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_pick (
      .cand_i (cand_set[p]),
      .base_i (ptr_q),
      .any_o  (path_any[p]),
      .idx_o  (path_idx[p])
    );
  end

  always_comb begin
    win_src = path_any[int'(SRC_REQ)] ? SRC_REQ : SRC_RR;
    win_any = |path_any;
    win_idx = path_idx[int'(win_src)];
    win_oh  = win_any ? (N_PORTS'(1) << win_idx) : '0;
    ptr_nxt = win_any ? IDX_W'(xos_wrap_inc(32'(win_idx), 32'(N_PORTS))) : ptr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

  xos_grant_reg #(.N_PORTS(N_PORTS)) u_greg (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_any_i (win_any),
    .win_oh_i  (win_oh),
    .gnt_o     (gnt_o),
    .gnt_vld_o (gnt_vld_o),
    .notify_o  (notify_o)
  );
endmodule

// File: rtl/xos_out_sched_chk.sv
module xos_out_sched_chk
  import xos_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS-1:0] occ_i,
  input logic [N_PORTS-1:0] rmreq_i,
  input logic [N_PORTS-1:0] gnt_o,
  input logic               gnt_vld_o,
  input logic [N_PORTS-1:0] notify_o,
  input logic [IDX_W-1:0]   ptr_q
);
  function automatic int unsigned oh_pos(input logic [N_PORTS-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < N_PORTS; i++) if (v[i]) r = i;
    return r;
  endfunction

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> $onehot(gnt_o)); // R7
  AST_GNT_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld_o |-> (gnt_o == '0)); // R7
  AST_REQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rmreq_i & occ_i)) |=> gnt_vld_o && ((gnt_o & ~$past(rmreq_i & occ_i)) == '0)); // R2
  AST_GNT_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    (|occ_i) |=> gnt_vld_o && ((gnt_o & ~$past(occ_i)) == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_i == '0) |=> !gnt_vld_o && $stable(ptr_q)); // R6
  AST_PTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> (ptr_q == IDX_W'(xos_wrap_inc(oh_pos(gnt_o), 32'(N_PORTS))))); // R5
  AST_NOTIFY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o == gnt_o); // R8
endmodule

bind xos_out_sched xos_out_sched_chk #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .occ_i     (occ_i),
  .rmreq_i   (rmreq_i),
  .gnt_o     (gnt_o),
  .gnt_vld_o (gnt_vld_o),
  .notify_o  (notify_o),
  .ptr_q     (ptr_q)
);

// File: tb/xos_out_sched_tb_top.sv
`timescale 1ns/1ps
module xos_out_sched_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] occ_i = '0;
  logic [N-1:0] rmreq_i = '0;
  logic [N-1:0] gnt_o;
  logic         gnt_vld_o;
  logic [N-1:0] notify_o;

  int n_checks = 0;
  int n_errors = 0;
  int m_ptr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xos_out_sched #(.N_PORTS(N)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ_i     (occ_i),
    .rmreq_i   (rmreq_i),
    .gnt_o     (gnt_o),
    .gnt_vld_o (gnt_vld_o),
    .notify_o  (notify_o)
  );

  function automatic int pick(input logic [N-1:0] cand, input int base);
    for (int k = 0; k < N; k++) begin
      if (cand[(base + k) % N]) return (base + k) % N;
    end
    return -1;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive a slot, let one edge pass, compare.
  task automatic slot(input logic [N-1:0] occ, input logic [N-1:0] req, input string tag);
    logic [N-1:0] eff, cand, exp_g;
    int exp_i;
    occ_i = occ;
    rmreq_i = req;
    eff = occ & req;
    cand = (eff != '0) ? eff : occ;
    exp_i = pick(cand, m_ptr);
    exp_g = (exp_i >= 0) ? (N'(1) << exp_i) : '0;
    @(posedge clk);
    @(negedge clk);
    chk(32'(gnt_o), 32'(exp_g), tag, "grant");
    chk(32'(gnt_vld_o), 32'(exp_i >= 0), tag, "valid");
    chk(32'(notify_o), 32'(exp_g), "R8", "notify");
    if (exp_i >= 0) m_ptr = (exp_i + 1) % N;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ro, rr;
    string tg;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(32'(gnt_o), 0, "R1", "grant in reset");
    chk(32'(gnt_vld_o), 0, "R1", "valid in reset");
    chk(32'(notify_o), 0, "R1", "notify in reset");
    rst_n = 1'b1;
    // R1: first slot after reset idle, then all occupied grants input 0
    slot('0, '0, "R1");
    slot('1, '0, "R1");                 // grant 0, ptr 1
    // R2: valid request behind nearer occupied buffers
    slot('1, 8'b0010_0000, "R2");       // grant 5, ptr 6
    // R9: next plain grant starts after the request winner
    slot('1, '0, "R9");                 // grant 6, ptr 7
    // R3: request to empty buffer 3 ignored, occupied 1 wins
    slot(8'b0000_0010, 8'b0000_1000, "R3"); // grant 1, ptr 2
    // R2 with wrap: ptr 2, requests at 0 and 4 -> 4
    slot('1, 8'b0001_0001, "R2");       // grant 4, ptr 5
    // R2 wrap-around: ptr 5, request only at 0
    slot(8'b1110_0001, 8'b0000_0001, "R2"); // grant 0, ptr 1
    // R5: wrap of pointer from the top input
    slot(8'b1000_0000, '0, "R5");       // grant 7, ptr 0
    slot('1, '0, "R5");                 // grant 0
    // R6: idle with stray requests, pointer must hold
    slot('0, 8'b1010_1010, "R6");
    slot('0, '0, "R6");
    slot('1, '0, "R6");                 // grant 1 proves pointer held
    // R4: plain round robin over sparse occupancy
    slot(8'b0100_0100, '0, "R4");       // ptr 2 -> grant 2
    slot(8'b0100_0100, '0, "R4");       // grant 6
    slot(8'b0100_0100, '0, "R4");       // grant 2
    // random mix
    for (int n = 0; n < 400; n++) begin
      ro = N'($urandom);
      rr = N'($urandom) & N'($urandom);
      if (($urandom % 8) == 0) ro = '0;
      if ((rr & ro) != '0)      tg = "R2";
      else if (ro != '0)        tg = (rr != '0) ? "R3" : "R4";
      else                      tg = "R6";
      slot(ro, rr, tg);
    end
    occ_i = '0;
    rmreq_i = '0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule